// File: doc/BRIEF.md
# Serial Flash Mode-Recovery Reset Sequencer

This block returns a serial NOR flash of unknown state to plain single-bit SPI operation before boot code touches it. After a warm restart the device may still be in quad, dual or execute-in-place operation, and the host cannot tell which. The block sends two all-ones frames: one 8 clocks long to leave quad operation and one 16 clocks long to leave dual operation. In both frames every data line is driven high, so a device waiting for the confirmation bit of an execute-in-place access also sees a 1 and leaves that state. The block then sends the reset-enable byte 0x66 and the reset byte 0x99 as two adjacent single-bit frames, with no other command between them.

After the reset byte the block keeps the bus idle for a programmable number of clock cycles, which covers the device reset time of about 30 microseconds. It then raises a ready flag. Each frame has its own chip-select low period. The four data lines are output-enabled only while chip select is low. The SPI clock half-period is set by a divider value, which the block captures together with the wait length when a start strobe arrives.

Top module: `flash_recover_seq`

## Requirements
- R1: After reset the chip select is high, SCK is low, all four output enables are 0 and ready is 0.
- R2: A start strobe from idle or ready launches exactly four frames, each inside its own chip-select low period, carrying 8, 16, 8 and 8 SCK rising edges in that order.
- R3: During the first two frames the output enables are 4'b1111 and the data outputs are 4'b1111 for the whole chip-select low period.
- R4: In the third and fourth frames DQ0 carries 0x66 and then 0x99, most significant bit first, valid at each SCK rising edge. The enable mask is 4'b1101: DQ1 is released, and DQ2 (write protect) and DQ3 (hold) are driven 1.
- R5: SCK is high only while chip select is low, and the data outputs do not change while SCK is high (SPI mode 0).
- R6: Every SCK high phase lasts D+1 clock cycles, where D is clk_div_i captured at start.
- R7: Between two frames chip select stays high for exactly D+3 clock cycles.
- R8: ready_o rises exactly D+W+3 clock cycles after the last chip-select release, where W is wait_cycles_i captured at start. No frame is sent in that interval.
- R9: All four output enables are 0 whenever chip select is high.
- R10: A start strobe while a sequence is running is ignored: no extra frame is sent and ready is not raised early.
- R11: ready_o stays high until the next start strobe. That strobe clears ready_o in the following cycle and runs the sequence again.
- R12: ready_o is 0 whenever chip select is low or SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled on each rising clock edge |
| clk_div_i | input | DIV_W | SCK half-period minus one, in clock cycles |
| wait_cycles_i | input | WAIT_W | Post-reset idle length in clock cycles |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| dq_o | output | 4 | Output values for DQ3..DQ0 |
| dq_oe_o | output | 4 | Output enables for DQ3..DQ0; 0 means released |
| ready_o | output | 1 | Device reset done, bus idle |

## Verification
The checker assumes that start_i is a clean synchronous level and that reset is applied before the first start. It also assumes that clk_div_i and wait_cycles_i are valid in the cycle start is taken; later changes to them have no effect. The bench drives every input at falling clock edges. It sets both settings before each start and also fires strobes in the middle of a running sequence. This covers the ignore case while keeping the checker's preconditions true.

// File: rtl/frp_pkg.sv
// Shared types and the fixed recovery frame list for the flash
// mode-recovery sequencer. Assumes frames of at most FRAME_W bits.
package frp_pkg;
    localparam int NUM_FRAMES = 4;
    localparam int IDX_W      = $clog2(NUM_FRAMES);
    localparam int FRAME_W    = 16;
    localparam int BITCNT_W   = $clog2(FRAME_W + 1);
    localparam int LANES      = 4;

    // Single-bit frames: DQ0 data, DQ1 released, DQ2/DQ3 held high.
    localparam logic [LANES-1:0] SINGLE_OE  = 4'b1101;
    localparam logic [LANES-1:0] SINGLE_VAL = 4'b1100;

    typedef struct packed {
        logic [BITCNT_W-1:0] nbits;
        logic [FRAME_W-1:0]  pattern;   // left aligned, MSB first
        logic                wide;      // all lanes driven high
    } frame_t;

    typedef enum logic [2:0] {E_IDLE, E_LEAD, E_HIGH, E_TRAIL, E_GAP} eng_state_t;
    typedef enum logic [1:0] {T_IDLE, T_FRAME, T_WAIT, T_READY} top_state_t;

    // Frame list: quad exit, dual exit, reset enable, reset.
    function automatic frame_t frame_of(input logic [IDX_W-1:0] idx);
        frame_t f;
        f.wide    = 1'b0;
        f.nbits   = BITCNT_W'(8);
        f.pattern = '0;
        case (idx)
            IDX_W'(0): begin f.wide = 1'b1; f.pattern = 16'hFFFF; end
            IDX_W'(1): begin f.wide = 1'b1; f.pattern = 16'hFFFF;
                             f.nbits = BITCNT_W'(16); end
            IDX_W'(2): f.pattern = 16'h6600;
            default:   f.pattern = 16'h9900;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/frp_half_tick.sv
// Half-period tick generator for SCK. Emits one tick every div_i+1
// cycles while enabled; restarts from zero whenever disabled.
module frp_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] hc;

    assign tick_o = en_i && (hc == div_i);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                hc <= '0;
        else if (!en_i || tick_o)  hc <= '0;
        else                       hc <= hc + 1'b1;
    end
endmodule

// File: rtl/frp_wait_timer.sv
// Down-counter for the post-reset idle time. Loaded with a cycle
// count, it counts down to zero and holds there.
module frp_wait_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] value_i,
    output logic              expired_o
);
    logic [WAIT_W-1:0] cnt;

    assign expired_o = (cnt == '0);

    // Load on request, otherwise step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load_i)        cnt <= value_i;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/frp_frame_engine.sv
// Sends one frame per load pulse: chip select low, mode-0 clocking of
// nbits bits, chip select high, one half-period gap, then a done pulse.
// Assumes load_i arrives only while the engine is idle.
module frp_frame_engine
    import frp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic [LANES-1:0] dq_o,
    output logic [LANES-1:0] dq_oe_o,
    output logic             done_o
);
    eng_state_t          st;
    logic                tick;
    frame_t              fr;
    logic [FRAME_W-1:0]  shreg;
    logic [BITCNT_W-1:0] left;
    logic                wide_q;

    assign fr = frame_of(idx_i);

    frp_half_tick #(.DIV_W(DIV_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st != E_IDLE),
        .div_i  (div_i),
        .tick_o (tick)
    );

    // Frame state machine: data changes only on SCK falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            cs_n_o <= 1'b1;
            sck_o  <= 1'b0;
            shreg  <= '0;
            left   <= '0;
            wide_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                E_IDLE: if (load_i) begin
                    cs_n_o <= 1'b0;
                    shreg  <= fr.pattern;
                    left   <= fr.nbits;
                    wide_q <= fr.wide;
                    st     <= E_LEAD;
                end
                E_LEAD: if (tick) begin
                    sck_o <= 1'b1;
                    st    <= E_HIGH;
                end
                E_HIGH: if (tick) begin
                    sck_o <= 1'b0;
                    if (left == BITCNT_W'(1)) begin
                        st <= E_TRAIL;
                    end else begin
                        left  <= left - 1'b1;
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        st    <= E_LEAD;
                    end
                end
                E_TRAIL: if (tick) begin
                    cs_n_o <= 1'b1;
                    st     <= E_GAP;
                end
                E_GAP: if (tick) begin
                    done_o <= 1'b1;
                    st     <= E_IDLE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // Per-lane drive: released with CS high, lane roles per frame type.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_data
            assign dq_o[l] = !cs_n_o && (wide_q || shreg[FRAME_W-1]);
        end else begin : g_fixed
            assign dq_o[l] = !cs_n_o && (wide_q || SINGLE_VAL[l]);
        end
        assign dq_oe_o[l] = !cs_n_o && (wide_q || SINGLE_OE[l]);
    end
endmodule

// File: rtl/flash_recover_seq.sv
// Top of the flash mode-recovery sequencer. On start, captures the
// divider and wait length, walks the frame list through the engine,
// idles for the wait length and then raises ready. Starts arriving
// while a sequence runs are ignored.
module flash_recover_seq
    import frp_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic [WAIT_W-1:0] wait_cycles_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe_o,
    output logic              ready_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    top_state_t        st;
    logic [IDX_W-1:0]  idx;
    logic              load;
    logic              done;
    logic              expired;
    logic              wait_load;
    logic [DIV_W-1:0]  div_q;
    logic [WAIT_W-1:0] wait_q;

    assign wait_load = (st == T_FRAME) && done && (idx == LAST_IDX);

    frp_frame_engine #(.DIV_W(DIV_W)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .idx_i   (idx),
        .div_i   (div_q),
        .cs_n_o  (cs_n_o),
        .sck_o   (sck_o),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o),
        .done_o  (done)
    );

    frp_wait_timer #(.WAIT_W(WAIT_W)) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wait_load),
        .value_i   (wait_q),
        .expired_o (expired)
    );

    // Sequence control: start capture, frame stepping, wait, ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= T_IDLE;
            idx     <= '0;
            load    <= 1'b0;
            ready_o <= 1'b0;
            div_q   <= '0;
            wait_q  <= '0;
        end else begin
            load <= 1'b0;
            case (st)
                T_IDLE, T_READY: if (start_i) begin
                    ready_o <= 1'b0;
                    div_q   <= clk_div_i;
                    wait_q  <= wait_cycles_i;
                    idx     <= '0;
                    load    <= 1'b1;
                    st      <= T_FRAME;
                end
                T_FRAME: if (done) begin
                    if (idx == LAST_IDX) begin
                        st <= T_WAIT;
                    end else begin
                        idx  <= idx + 1'b1;
                        load <= 1'b1;
                    end
                end
                T_WAIT: if (expired) begin
                    ready_o <= 1'b1;
                    st      <= T_READY;
                end
                default: st <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_recover_seq_chk.sv
// Assertion checker for flash_recover_seq, bound to every instance.
// Assumes start_i is a synchronous, known level.
module flash_recover_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cs_n_o,
    input logic       sck_o,
    input logic [3:0] dq_o,
    input logic [3:0] dq_oe_o,
    input logic       ready_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cs_n_o && !sck_o && !ready_o && dq_oe_o == 4'b0000));

    assert_wide_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && dq_oe_o == 4'b1111) |-> dq_o == 4'b1111);

    assert_single_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && dq_oe_o != 4'b1111) |-> (dq_oe_o == 4'b1101 && dq_o[3:2] == 2'b11));

    assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(dq_o));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> dq_oe_o == 4'b0000);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && start_i) |=> !ready_o);

    assert_ready_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> ready_o);

    assert_ready_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cs_n_o && !sck_o));
endmodule

bind flash_recover_seq flash_recover_seq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .sck_o   (sck_o),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o),
    .ready_o (ready_o)
);

// File: tb/flash_recover_seq_tb_top.sv
`timescale 1ns/1ps
// Bench for flash_recover_seq: a vector table of divider/wait settings
// walked by one loop, then directed reset, mid-run start and restart tests.
module flash_recover_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  clk_div_i = '0;
    logic [15:0] wait_cycles_i = '0;
    logic        cs_n_o, sck_o, ready_o;
    logic [3:0]  dq_o, dq_oe_o;

    int tests = 0;
    int fails = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    flash_recover_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_div_i(clk_div_i),
        .wait_cycles_i(wait_cycles_i), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .ready_o(ready_o)
    );

    // {divider, wait length}
    localparam logic [23:0] VEC [0:5] = '{
        {8'd0, 16'd0}, {8'd0, 16'd5}, {8'd1, 16'd10},
        {8'd3, 16'd0}, {8'd7, 16'd40}, {8'd2, 16'd300}
    };
    localparam int EXP_BITS [0:3] = '{8, 16, 8, 8};
    localparam logic [7:0] EXP_CMD [0:3] = '{8'hFF, 8'hFF, 8'h66, 8'h99};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Runs one full sequence and checks frames, timing and ready.
    task automatic run_seq(input int d, input int w, input bit mid_start);
        int frame = 0, bits = 0, hi = 0, gap = 0;
        logic [15:0] sh = '0;
        bit prev_cs = 1'b1, prev_sck = 1'b0, fin = 1'b0;
        bit bad_drive = 1'b0, bad_half = 1'b0, bad_ready = 1'b0;
        bit bad_mode = 1'b0, bad_rel = 1'b0;
        @(negedge clk);
        clk_div_i = 8'(d);
        wait_cycles_i = 16'(w);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(ready_o == 1'b0, "R11", "ready after start", int'(ready_o), 0);
        for (int cyc = 0; cyc < 30000 && !fin; cyc++) begin
            @(negedge clk);
            start_i = (mid_start && cyc == 40);
            if (frame == 4) begin
                if (ready_o) begin
                    check(gap == d + w + 3, "R8", "cycles to ready", gap, d + w + 3);
                    fin = 1'b1;
                end
            end else if (ready_o) bad_ready = 1'b1;
            if (prev_cs && !cs_n_o) begin
                if (frame > 0) check(gap == d + 3, "R7", "CS high gap", gap, d + 3);
                if (frame >= 4) check(0, "R10", "extra frame", frame + 1, 4);
                bits = 0; sh = '0; bad_drive = 1'b0;
            end
            if (!cs_n_o && frame < 4) begin
                if (frame < 2) begin
                    if (dq_oe_o != 4'hF || dq_o != 4'hF) bad_drive = 1'b1;
                end else if (dq_oe_o != 4'b1101 || dq_o[3:2] != 2'b11) bad_drive = 1'b1;
            end
            if (cs_n_o && dq_oe_o != 4'h0) bad_rel = 1'b1;
            if (cs_n_o && sck_o) bad_mode = 1'b1;
            if (sck_o && !prev_sck) begin
                bits++; sh = {sh[14:0], dq_o[0]}; hi = 1;
            end else if (sck_o) hi++;
            if (!sck_o && prev_sck && hi != d + 1) bad_half = 1'b1;
            if (!prev_cs && cs_n_o) begin
                if (frame < 4) begin
                    check(bits == EXP_BITS[frame], "R2", "clocks in frame", bits, EXP_BITS[frame]);
                    if (frame >= 2)
                        check(sh[7:0] == EXP_CMD[frame], "R4", "command byte",
                              int'(sh[7:0]), int'(EXP_CMD[frame]));
                    if (frame < 2) check(!bad_drive, "R3", "exit-frame lanes", int'(bad_drive), 0);
                    else           check(!bad_drive, "R4", "command-frame lanes", int'(bad_drive), 0);
                end
                frame++; gap = 0;
            end
            if (cs_n_o) gap++;
            prev_cs = cs_n_o; prev_sck = sck_o;
        end
        start_i = 1'b0;
        check(fin, "R8", "ready reached", int'(fin), 1);
        check(frame == 4, "R2", "frame count", frame, 4);
        check(!bad_half, "R6", "SCK high length", int'(bad_half), 0);
        check(!bad_ready, "R12", "ready while busy", int'(bad_ready), 0);
        check(!bad_mode, "R5", "SCK high with CS high", int'(bad_mode), 0);
        check(!bad_rel, "R9", "lanes released", int'(bad_rel), 0);
        // Quiet interval: no frame and ready held (R10, R11).
        for (int q = 0; q < 40; q++) begin
            @(negedge clk);
            if (!cs_n_o || !ready_o) bad_mode = 1'b1;
        end
        check(!bad_mode, "R11", "ready held, bus idle", int'(bad_mode), 0);
    endtask

    initial begin
        #(4 * 190000);
        check(0, "WATCHDOG", "run ended by timeout", 1, 0);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o == 1'b1, "R1", "cs_n after reset", int'(cs_n_o), 1);
        check(sck_o == 1'b0, "R1", "sck after reset", int'(sck_o), 0);
        check(dq_oe_o == 4'h0, "R1", "enables after reset", int'(dq_oe_o), 0);
        check(ready_o == 1'b0, "R1", "ready after reset", int'(ready_o), 0);
        repeat (20) @(negedge clk);
        check(ready_o == 1'b0 && cs_n_o, "R1", "idle without start", int'(ready_o), 0);

        // Vector table walk; each run starts from ready of the previous.
        for (int i = 0; i < 6; i++) begin
            run_seq(int'(VEC[i][23:16]), int'(VEC[i][15:0]), 1'b0);
        end

        // R10: start strobe in the middle of a running sequence.
        run_seq(1, 12, 1'b1);

        // R1: reset in the middle of a sequence returns outputs to idle.
        @(negedge clk);
        clk_div_i = 8'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        check(cs_n_o == 1'b0, "R2", "frame running before reset", int'(cs_n_o), 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(cs_n_o == 1'b1 && !sck_o && dq_oe_o == 4'h0 && !ready_o, "R1",
              "outputs after mid-run reset", int'({cs_n_o, sck_o, ready_o}), 4);
        repeat (200) @(negedge clk);
        check(cs_n_o == 1'b1 && !ready_o, "R1", "stays idle after reset",
              int'({cs_n_o, ready_o}), 2);

        // R11: fresh run after reset still completes.
        run_seq(0, 3, 1'b0);
        finish_up();
    end
endmodule